// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block follows the power state of a processor core from the control lines a platform drives toward it. It moves through Normal, Stop-Grant, Sleep and Deep Sleep. After Deep Sleep it passes through a timed wait for the clock generator to relock, and only then does it return to Sleep. The current state is presented as a one-hot vector.

Two flags tell neighbouring logic whether the core can answer snoops and whether it may latch interrupts. A sticky protocol-violation flag marks input activity that is illegal while the core is in its deepest state or on its way back from it. A reset request has the highest priority: it returns the machine to Normal from any state, including Sleep, without passing through Stop-Grant.

The relock wait is counted in ticks of a free-running timebase input. Its length is the product of a duration in microseconds and a tick rate, both set by parameters. With the defaults the wait is 30 ticks.

Top module: `lps_sequencer`

## Requirements
- R1: While `rst_n` is low, and after it is released, the state vector reads Normal, `snoop_ok` and `irq_latch_en` are high and `violation` is low.
- R2: From Normal, a high `stop_req` moves the block to Stop-Grant on the next edge. From Stop-Grant, a cycle with both `stop_req` and `sleep_req` low moves it back to Normal.
- R3: From Stop-Grant, `sleep_req` high together with `stop_req` high moves the block to Sleep. From Sleep, `sleep_req` low with `deep_req` low moves it back to Stop-Grant.
- R4: In Sleep, a high `deep_req` moves the block to Deep Sleep, and this takes priority over the Sleep exit. In Normal and Stop-Grant, `deep_req` has no effect on the state and never raises `violation`.
- R5: In Deep Sleep, a low `deep_req` moves the block to the relock wait. The wait counts only cycles with `tick` high. The state moves to Sleep on the edge that samples the RELOCK_TICKS-th tick (30 by default).
- R6: `snoop_ok` and `irq_latch_en` are low in Deep Sleep and in the relock wait, and high in every other state.
- R7: From entry into Deep Sleep until Stop-Grant is reached again, any change of `stop_req`, or any change of `sleep_req` outside Sleep, sets `violation` one edge later. `violation` then stays set until a reset request.
- R8: Changes of `deep_req` never set `violation`. A fall of `sleep_req` while in Sleep after the relock wait is a legal exit and does not set `violation`.
- R9: A high `reset_req` sends the block from any state, including Sleep, directly to Normal on the next edge. It also clears `violation` and the relock count. It overrides every other input.
- R10: The state vector `state_oh` uses bit 0 for Normal, bit 1 for Stop-Grant, bit 2 for Sleep, bit 3 for Deep Sleep and bit 4 for the relock wait. Exactly one bit is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| stop_req | input | 1 | Stop-clock request from the platform |
| sleep_req | input | 1 | Sleep request |
| deep_req | input | 1 | Deep-sleep request |
| reset_req | input | 1 | Synchronous processor reset request |
| tick | input | 1 | Timebase tick, one cycle wide |
| state_oh | output | 5 | One-hot power state |
| snoop_ok | output | 1 | Core can answer snoops |
| irq_latch_en | output | 1 | Core may latch interrupts |
| violation | output | 1 | Sticky protocol-violation flag |

## Verification
The hardest situation to reach from the ports is the end of the relock wait. The bench must first walk the machine through Normal, Stop-Grant and Sleep into Deep Sleep while holding every other request steady. It then releases only `deep_req` and pulses `tick` one cycle at a time, with idle cycles in between. It confirms the relock state just before the last tick and Sleep just after it. The same path is reused to show that the legal Sleep exit leaves `violation` clear, while a stray toggle of `stop_req` during Deep Sleep sets it.

// File: rtl/lps_pkg.sv
package lps_pkg;

    localparam int NUM_STATES = 5;

    // One-hot encoding; bit order is visible on the state_oh port
    typedef enum logic [NUM_STATES-1:0] {
        ST_NORMAL  = 5'b00001,
        ST_STOPGNT = 5'b00010,
        ST_SLEEP   = 5'b00100,
        ST_DEEP    = 5'b01000,
        ST_RELOCK  = 5'b10000
    } lps_state_e;

endpackage

// File: rtl/lps_relock_timer.sv
module lps_relock_timer #(
    parameter int CNT_MAX = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] LAST = CW'(CNT_MAX - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear || !run) begin
            r_d.cnt = '0;
        end else if (tick && r_q.cnt != LAST) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    assign done = run && !clear && tick && (r_q.cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R9: a clear always empties the count
    a_r9_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (r_q.cnt == '0));

    // R5: count never moves without a tick
    a_r5_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && !tick) |=> $stable(r_q.cnt));

endmodule

// File: rtl/lps_bus_monitor.sv
module lps_bus_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic in_deep,
    input  logic in_sleep,
    input  logic in_stopgnt,
    input  logic stop_req,
    input  logic sleep_req,
    output logic violation
);
    typedef struct packed {
        logic guard;
        logic viol;
        logic stop_prev;
        logic sleep_prev;
    } mon_t;

    mon_t m_d, m_q;
    logic watching;
    logic bad_edge;

    always_comb begin
        watching = m_q.guard || in_deep;
        bad_edge = (stop_req != m_q.stop_prev) ||
                   ((sleep_req != m_q.sleep_prev) && !in_sleep);

        m_d            = m_q;
        m_d.stop_prev  = stop_req;
        m_d.sleep_prev = sleep_req;
        if (clear) begin
            m_d.guard = 1'b0;
            m_d.viol  = 1'b0;
        end else begin
            if (in_deep)         m_d.guard = 1'b1;
            else if (in_stopgnt) m_d.guard = 1'b0;
            if (watching && bad_edge) m_d.viol = 1'b1;
        end
    end

    assign violation = m_q.viol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    // R7: flag is sticky until cleared
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (violation && !clear) |=> violation);

    // R9: clear wins
    a_r9_viol_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !violation);

endmodule

// File: rtl/lps_sequencer.sv
module lps_sequencer
    import lps_pkg::*;
#(
    parameter int RELOCK_US    = 30,
    parameter int TICKS_PER_US = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stop_req,
    input  logic                  sleep_req,
    input  logic                  deep_req,
    input  logic                  reset_req,
    input  logic                  tick,
    output logic [NUM_STATES-1:0] state_oh,
    output logic                  snoop_ok,
    output logic                  irq_latch_en,
    output logic                  violation
);
    localparam int RELOCK_TICKS = RELOCK_US * TICKS_PER_US;

    typedef struct packed {
        lps_state_e st;
    } seq_t;

    seq_t s_d, s_q;
    logic relock_done;
    logic quiet;

    lps_relock_timer #(.CNT_MAX(RELOCK_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (reset_req),
        .run   (s_q.st == ST_RELOCK),
        .tick  (tick),
        .done  (relock_done)
    );

    lps_bus_monitor u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (reset_req),
        .in_deep    (s_q.st == ST_DEEP),
        .in_sleep   (s_q.st == ST_SLEEP),
        .in_stopgnt (s_q.st == ST_STOPGNT),
        .stop_req   (stop_req),
        .sleep_req  (sleep_req),
        .violation  (violation)
    );

    always_comb begin
        s_d = s_q;
        if (reset_req) begin
            s_d.st = ST_NORMAL;
        end else begin
            unique case (s_q.st)
                ST_NORMAL:  if (stop_req) s_d.st = ST_STOPGNT;
                ST_STOPGNT: begin
                    if (stop_req && sleep_req)        s_d.st = ST_SLEEP;
                    else if (!stop_req && !sleep_req) s_d.st = ST_NORMAL;
                end
                ST_SLEEP: begin
                    if (deep_req)        s_d.st = ST_DEEP;
                    else if (!sleep_req) s_d.st = ST_STOPGNT;
                end
                ST_DEEP:    if (!deep_req)   s_d.st = ST_RELOCK;
                ST_RELOCK:  if (relock_done) s_d.st = ST_SLEEP;
                default:    s_d.st = ST_NORMAL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.st <= ST_NORMAL;
        else        s_q    <= s_d;
    end

    assign quiet        = (s_q.st == ST_DEEP) || (s_q.st == ST_RELOCK);
    assign state_oh     = s_q.st;
    assign snoop_ok     = !quiet;
    assign irq_latch_en = !quiet;

    // R10: exactly one state bit
    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_oh) == 1);

    // R4: Deep Sleep entered only from Sleep
    a_r4_deep_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_oh[3]) |-> $past(state_oh[2]));

    // R9: reset request lands in Normal with a clear flag
    a_r9_reset_normal: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (state_oh == 5'b00001) && !violation);

    // R5: relock wait cannot end without a tick
    a_r5_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[4] && !tick && !reset_req) |=> state_oh[4]);

    // R6: deep states report no snoop and no interrupt latch
    a_r6_quiet_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[3] || state_oh[4]) |-> (!snoop_ok && !irq_latch_en));

endmodule

// File: tb/sim_lps_sequencer.sv
module sim_lps_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 0, sleep_req = 0, deep_req = 0, reset_req = 0, tick = 0;
    logic [4:0] state_oh;
    logic snoop_ok, irq_latch_en, violation;

    localparam logic [4:0] NRM = 5'b00001, SG = 5'b00010, SLP = 5'b00100,
                           DP = 5'b01000, RLK = 5'b10000;
    localparam int NTICK = 30;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit ended = 0;

    lps_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .sleep_req(sleep_req),
        .deep_req(deep_req), .reset_req(reset_req), .tick(tick),
        .state_oh(state_oh), .snoop_ok(snoop_ok), .irq_latch_en(irq_latch_en),
        .violation(violation)
    );

    always #10 clk = ~clk;

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic quiesce();
        reset_req = 1; stop_req = 0; sleep_req = 0; deep_req = 0; tick = 0;
        step();
        reset_req = 0;
        step();
    endtask

    task automatic go_sleep();
        stop_req = 1; step();
        sleep_req = 1; step();
    endtask

    task automatic t_reset_state();
        chk("R1 state in reset", state_oh, NRM);
        rst_n = 1;
        step();
        chk("R1 state after reset", state_oh, NRM);
        chk("R1 flags after reset", {snoop_ok, irq_latch_en, violation}, 5'b110);
    endtask

    task automatic t_stopgrant();
        quiesce();
        stop_req = 1; step();
        chk("R2 enter stop-grant", state_oh, SG);
        stop_req = 0; step();
        chk("R2 back to normal", state_oh, NRM);
    endtask

    task automatic t_sleep_cycle();
        quiesce();
        go_sleep();
        chk("R3 enter sleep", state_oh, SLP);
        chk("R6 flags in sleep", {snoop_ok, irq_latch_en}, 5'b11);
        sleep_req = 0; step();
        chk("R3 sleep exit", state_oh, SG);
    endtask

    task automatic t_deep_ignored();
        quiesce();
        deep_req = 1; step();
        chk("R4 deep ignored in normal", state_oh, NRM);
        stop_req = 1; step(2);
        chk("R4 deep ignored in stop-grant", state_oh, SG);
        chk("R8 no violation from deep_req", {4'b0, violation}, 5'b0);
    endtask

    task automatic t_deep_relock();
        quiesce();
        go_sleep();
        deep_req = 1; step();
        chk("R4 enter deep", state_oh, DP);
        chk("R6 flags in deep", {snoop_ok, irq_latch_en}, 5'b00);
        deep_req = 0; step();
        chk("R5 enter relock", state_oh, RLK);
        chk("R6 flags in relock", {snoop_ok, irq_latch_en}, 5'b00);
        for (int k = 0; k < NTICK - 1; k++) begin
            tick = 1; step();
            tick = 0; step();
        end
        chk("R5 still relocking before last tick", state_oh, RLK);
        tick = 1; step();
        tick = 0;
        chk("R5 sleep after last tick", state_oh, SLP);
        sleep_req = 0; step();
        chk("R8 legal exit to stop-grant", state_oh, SG);
        chk("R8 legal path no violation", {4'b0, violation}, 5'b0);
    endtask

    task automatic t_violation();
        quiesce();
        go_sleep();
        deep_req = 1; step();
        stop_req = 0; step();
        chk("R7 violation on stop toggle", {4'b0, violation}, 5'b1);
        stop_req = 1; deep_req = 0; step(3);
        chk("R7 violation sticky", {4'b0, violation}, 5'b1);
        reset_req = 1; step();
        reset_req = 0;
        chk("R9 reset clears violation", {4'b0, violation}, 5'b0);
    endtask

    task automatic t_reset_from_sleep();
        quiesce();
        go_sleep();
        reset_req = 1; step();
        chk("R9 reset from sleep to normal", state_oh, NRM);
        reset_req = 0; stop_req = 0; sleep_req = 0;
        step();
        chk("R10 single state bit", 5'($countones(state_oh)), 5'd1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !ended) begin
            ended = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(2);
        t_reset_state();
        t_stopgrant();
        t_sleep_cycle();
        t_deep_ignored();
        t_deep_relock();
        t_violation();
        t_reset_from_sleep();
        ended = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule